// File: doc/BRIEF.md
# PWM Channel Time-Base and Output Action Unit

This block is a single PWM channel. A 16-bit time-base counter advances on a prescaled tick enable and runs in one of three counting modes. Up counting and down counting give edge-aligned (asymmetric) waveforms. Up-down counting gives centre-aligned (symmetric) waveforms. Two compare values and a period value are written to shadow inputs. They are copied into active registers each time the counter sits at zero, so a change made mid-cycle never breaks a PWM period.

Six counter events are detected on every tick: zero, period, compare A rising, compare A falling, compare B rising and compare B falling. Each of the two outputs has its own table that gives, for every event, one of four actions: nothing, drive low, drive high or toggle. Software can override either output with a forced level. A synchronisation input can load a phase value into the counter and choose the direction it takes afterwards. A selectable synchronisation output lets several channels be chained. Registered event strobes feed interrupt logic. The counter value and its direction flag are brought out for neighbouring logic.

Top module: `pwm_chan`

## Requirements
- R1: While reset is asserted and on its release, the counter is 0, the direction flag is up (1), the active period and compare registers are 0, and every output and strobe is 0.
- R2: In mode 0 (up), each tick increments the counter. A tick taken with the counter at or above the active period sets it to 0.
- R3: In mode 1 (down), each tick decrements the counter. A tick taken at 0, or above the active period, loads the active period.
- R4: In mode 2 (up-down), the counter climbs while the direction flag is 1. A tick at or above the active period clears the flag and steps down (staying at 0 if already 0). A tick at 0 with the flag clear sets the flag and steps to 1 (to 0 when the period is 0).
- R5: The period, compare A and compare B inputs are copied into the active registers only on a tick taken with the counter at 0. The values that were active during that tick still apply to it.
- R6: On each tick, the current counter value is compared with the active registers. A compare event counts as rising when the mode is up, falling when the mode is down, and follows the direction flag in up-down mode. Each output's 12-bit action word holds 2-bit codes at these bit positions: zero [1:0], period [3:2], compare A rising [5:4], compare A falling [7:6], compare B rising [9:8], compare B falling [11:10]. The codes are 0 none, 1 low, 2 high, 3 toggle. The output takes the new level one clock later.
- R7: When several events with non-zero codes occur on one tick, only one code applies, in this priority order: zero, then period, then compare B, then compare A.
- R8: While an output's force enable is 1, that output takes the force level on the next clock, whatever the event table says.
- R9: When sync enable and sync input are both 1, the counter loads the phase value and the direction flag loads the sync direction bit on the next clock. This takes priority over counting and does not need a tick.
- R10: The sync output is registered. Select 0 passes the sync input, 1 marks a zero event, 2 marks a compare B event in either direction, and 3 holds it at 0.
- R11: The zero, period, compare A and compare B strobes go high one clock after a tick on which the matching event happened. Both compare directions raise the same strobe.
- R12: In mode 3 (hold), ticks are ignored. The counter, the direction flag and the active registers keep their values, and no event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled time-base clock enable |
| mode_i | input | 2 | Counter mode: 0 up, 1 down, 2 up-down, 3 hold |
| period_i | input | 16 | Shadow period value |
| cmpa_i | input | 16 | Shadow compare A value |
| cmpb_i | input | 16 | Shadow compare B value |
| phase_i | input | 16 | Value loaded on synchronisation |
| sync_in_i | input | 1 | Synchronisation input |
| sync_en_i | input | 1 | Enables phase load from sync input |
| sync_dir_up_i | input | 1 | Direction flag value taken on sync |
| sync_sel_i | input | 2 | Sync output source select |
| act_a_i | input | 12 | Event action table for output A |
| act_b_i | input | 12 | Event action table for output B |
| frc_en_i | input | 2 | Force enables, bit 0 output A, bit 1 output B |
| frc_val_i | input | 2 | Force levels, bit 0 output A, bit 1 output B |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| sync_out_o | output | 1 | Synchronisation output |
| evt_zero_o | output | 1 | Zero event strobe |
| evt_prd_o | output | 1 | Period event strobe |
| evt_cmpa_o | output | 1 | Compare A event strobe |
| evt_cmpb_o | output | 1 | Compare B event strobe |
| cnt_o | output | 16 | Time-base counter value |
| dir_up_o | output | 1 | Counter direction flag |

## Verification
The bench sweeps many random configurations: all four modes, short periods (0 to 23) so every event fires often, compare values on, inside and just past the period, gappy and continuous tick patterns, and random action tables. Random tables make many ticks where two or more events coincide, which separates a correct priority order from a wrong one. Rare sync pulses, mid-run shadow changes and short force bursts show whether phase loading, reload-at-zero timing and the force override are correct. A directed run changes the period while the counter is mid-cycle, to show that the old period still finishes the current cycle.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_HOLD = 2'd3
    } cnt_mode_e;

    localparam logic [1:0] ACT_NONE = 2'd0;
    localparam logic [1:0] ACT_LOW  = 2'd1;
    localparam logic [1:0] ACT_HIGH = 2'd2;
    localparam logic [1:0] ACT_TOG  = 2'd3;

    localparam int ACT_W = 12;

    typedef struct packed {
        logic zero;
        logic prd;
        logic ca_up;
        logic ca_dn;
        logic cb_up;
        logic cb_dn;
    } evt_t;

    // Highest-priority occurring event with a non-zero code wins:
    // zero, period, compare B, compare A.
    function automatic logic [1:0] pick_action(evt_t ev, logic [ACT_W-1:0] act);
        logic [1:0] code;
        code = ACT_NONE;
        if (ev.zero && act[1:0] != ACT_NONE)
            code = act[1:0];
        else if (ev.prd && act[3:2] != ACT_NONE)
            code = act[3:2];
        else if (ev.cb_up && act[9:8] != ACT_NONE)
            code = act[9:8];
        else if (ev.cb_dn && act[11:10] != ACT_NONE)
            code = act[11:10];
        else if (ev.ca_up && act[5:4] != ACT_NONE)
            code = act[5:4];
        else if (ev.ca_dn && act[7:6] != ACT_NONE)
            code = act[7:6];
        return code;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  cnt_mode_e     mode_i,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] cmpa_i,
    input  logic [CW-1:0] cmpb_i,
    input  logic [CW-1:0] phase_i,
    input  logic          sync_load_i,
    input  logic          sync_dir_up_i,
    output logic [CW-1:0] cnt_o,
    output logic          dir_up_o,
    output logic [CW-1:0] prd_act_o,
    output evt_t          ev_o
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
        logic [CW-1:0] prd;
        logic [CW-1:0] ca;
        logic [CW-1:0] cb;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      run;
    logic      eff_up;

    always_comb begin
        st_d   = st_q;
        run    = tick_i && (mode_i != MODE_HOLD);
        unique case (mode_i)
            MODE_UP:   eff_up = 1'b1;
            MODE_DOWN: eff_up = 1'b0;
            default:   eff_up = st_q.up;
        endcase

        ev_o.zero  = run && (st_q.cnt == ZERO);
        ev_o.prd   = run && (st_q.cnt == st_q.prd);
        ev_o.ca_up = run && (st_q.cnt == st_q.ca) && eff_up;
        ev_o.ca_dn = run && (st_q.cnt == st_q.ca) && !eff_up;
        ev_o.cb_up = run && (st_q.cnt == st_q.cb) && eff_up;
        ev_o.cb_dn = run && (st_q.cnt == st_q.cb) && !eff_up;

        if (run && st_q.cnt == ZERO) begin
            st_d.prd = period_i;
            st_d.ca  = cmpa_i;
            st_d.cb  = cmpb_i;
        end

        if (run) begin
            unique case (mode_i)
                MODE_UP: begin
                    st_d.up  = 1'b1;
                    st_d.cnt = (st_q.cnt >= st_q.prd) ? ZERO : st_q.cnt + ONE;
                end
                MODE_DOWN: begin
                    st_d.up  = 1'b0;
                    st_d.cnt = (st_q.cnt == ZERO || st_q.cnt > st_q.prd) ?
                               st_q.prd : st_q.cnt - ONE;
                end
                default: begin
                    if (st_q.up) begin
                        if (st_q.cnt >= st_q.prd) begin
                            st_d.up  = 1'b0;
                            st_d.cnt = (st_q.cnt == ZERO) ? ZERO : st_q.cnt - ONE;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else if (st_q.cnt == ZERO) begin
                        st_d.up  = 1'b1;
                        st_d.cnt = (st_q.prd == ZERO) ? ZERO : ONE;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
            endcase
        end

        if (sync_load_i) begin
            st_d.cnt = phase_i;
            st_d.up  = sync_dir_up_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.up  <= 1'b1;
            st_q.prd <= '0;
            st_q.ca  <= '0;
            st_q.cb  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign dir_up_o  = st_q.up;
    assign prd_act_o = st_q.prd;

endmodule

// File: rtl/pwm_action.sv
module pwm_action
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             ev_i,
    input  logic [ACT_W-1:0] act_i,
    input  logic             frc_en_i,
    input  logic             frc_val_i,
    output logic             out_o
);

    logic       out_d, out_q;
    logic [1:0] code;

    always_comb begin
        code  = pick_action(ev_i, act_i);
        out_d = out_q;
        if (frc_en_i) begin
            out_d = frc_val_i;
        end else begin
            unique case (code)
                ACT_LOW:  out_d = 1'b0;
                ACT_HIGH: out_d = 1'b1;
                ACT_TOG:  out_d = ~out_q;
                default:  out_d = out_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign out_o = out_q;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CW    = 16,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic [CW-1:0]    period_i,
    input  logic [CW-1:0]    cmpa_i,
    input  logic [CW-1:0]    cmpb_i,
    input  logic [CW-1:0]    phase_i,
    input  logic             sync_in_i,
    input  logic             sync_en_i,
    input  logic             sync_dir_up_i,
    input  logic [1:0]       sync_sel_i,
    input  logic [ACT_W-1:0] act_a_i,
    input  logic [ACT_W-1:0] act_b_i,
    input  logic [N_OUT-1:0] frc_en_i,
    input  logic [N_OUT-1:0] frc_val_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             sync_out_o,
    output logic             evt_zero_o,
    output logic             evt_prd_o,
    output logic             evt_cmpa_o,
    output logic             evt_cmpb_o,
    output logic [CW-1:0]    cnt_o,
    output logic             dir_up_o
);

    typedef struct packed {
        logic zero;
        logic prd;
        logic cmpa;
        logic cmpb;
        logic sync;
    } strobe_t;

    evt_t             ev;
    logic [CW-1:0]    prd_act;
    logic             sync_load;
    logic [ACT_W-1:0] act_tbl [N_OUT];
    logic [N_OUT-1:0] pwm_out;
    strobe_t          sb_d, sb_q;

    assign sync_load  = sync_en_i && sync_in_i;
    assign act_tbl[0] = act_a_i;
    assign act_tbl[1] = act_b_i;

    pwm_timebase #(.CW(CW)) u_tb (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .mode_i       (cnt_mode_e'(mode_i)),
        .period_i     (period_i),
        .cmpa_i       (cmpa_i),
        .cmpb_i       (cmpb_i),
        .phase_i      (phase_i),
        .sync_load_i  (sync_load),
        .sync_dir_up_i(sync_dir_up_i),
        .cnt_o        (cnt_o),
        .dir_up_o     (dir_up_o),
        .prd_act_o    (prd_act),
        .ev_o         (ev)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        pwm_action u_act (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev),
            .act_i    (act_tbl[g]),
            .frc_en_i (frc_en_i[g]),
            .frc_val_i(frc_val_i[g]),
            .out_o    (pwm_out[g])
        );
    end

    always_comb begin
        sb_d.zero = ev.zero;
        sb_d.prd  = ev.prd;
        sb_d.cmpa = ev.ca_up || ev.ca_dn;
        sb_d.cmpb = ev.cb_up || ev.cb_dn;
        unique case (sync_sel_i)
            2'd0:    sb_d.sync = sync_in_i;
            2'd1:    sb_d.sync = ev.zero;
            2'd2:    sb_d.sync = ev.cb_up || ev.cb_dn;
            default: sb_d.sync = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign pwm_a_o    = pwm_out[0];
    assign pwm_b_o    = pwm_out[1];
    assign sync_out_o = sb_q.sync;
    assign evt_zero_o = sb_q.zero;
    assign evt_prd_o  = sb_q.prd;
    assign evt_cmpa_o = sb_q.cmpa;
    assign evt_cmpb_o = sb_q.cmpb;

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic [1:0]    mode_i,
    input logic [CW-1:0] phase_i,
    input logic          sync_in_i,
    input logic          sync_en_i,
    input logic [1:0]    sync_sel_i,
    input logic [1:0]    frc_en_i,
    input logic [1:0]    frc_val_i,
    input logic          pwm_a_o,
    input logic          pwm_b_o,
    input logic          sync_out_o,
    input logic          evt_zero_o,
    input logic [CW-1:0] cnt_o,
    input logic          dir_up_o,
    input logic [CW-1:0] prd_act
);

    logic nosync;
    assign nosync = !(sync_en_i && sync_in_i);

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && tick_i && nosync && cnt_o >= prd_act) |=> cnt_o == '0);

    assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && tick_i && nosync && cnt_o == '0) |=> cnt_o == $past(prd_act));

    assert_turn_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && tick_i && nosync && !dir_up_o && cnt_o == '0) |=> dir_up_o);

    assert_force_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frc_en_i[0] |=> pwm_a_o == $past(frc_val_i[0]));

    assert_force_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frc_en_i[1] |=> pwm_b_o == $past(frc_val_i[1]));

    assert_phase_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en_i && sync_in_i) |=> cnt_o == $past(phase_i));

    assert_sync_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel_i == 2'd3) |=> !sync_out_o);

    assert_zero_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i != 2'd3 && cnt_o == '0) |=> evt_zero_o);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && nosync) |=> $stable(cnt_o));

endmodule

bind pwm_chan pwm_chan_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .mode_i    (mode_i),
    .phase_i   (phase_i),
    .sync_in_i (sync_in_i),
    .sync_en_i (sync_en_i),
    .sync_sel_i(sync_sel_i),
    .frc_en_i  (frc_en_i),
    .frc_val_i (frc_val_i),
    .pwm_a_o   (pwm_a_o),
    .pwm_b_o   (pwm_b_o),
    .sync_out_o(sync_out_o),
    .evt_zero_o(evt_zero_o),
    .cnt_o     (cnt_o),
    .dir_up_o  (dir_up_o),
    .prd_act   (prd_act)
);

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [15:0] period_i = '0, cmpa_i = '0, cmpb_i = '0, phase_i = '0;
    logic        sync_in_i = 1'b0, sync_en_i = 1'b0, sync_dir_up_i = 1'b0;
    logic [1:0]  sync_sel_i = 2'd3;
    logic [11:0] act_a_i = '0, act_b_i = '0;
    logic [1:0]  frc_en_i = '0, frc_val_i = '0;
    logic        pwm_a_o, pwm_b_o, sync_out_o;
    logic        evt_zero_o, evt_prd_o, evt_cmpa_o, evt_cmpb_o;
    logic [15:0] cnt_o;
    logic        dir_up_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_cnt, m_prd, m_ca, m_cb;
    logic        m_up, m_a, m_b, m_ez, m_ep, m_eca, m_ecb, m_so;
    string       t_cnt, t_a, t_b;

    always #5 clk = ~clk;

    pwm_chan u_dut (.*);

    function automatic logic [1:0] resolve(logic ez, logic ep, logic cau, logic cad,
                                           logic cbu, logic cbd, logic [11:0] t);
        if (ez && t[1:0] != 0) return t[1:0];
        if (ep && t[3:2] != 0) return t[3:2];
        if (cbu && t[9:8] != 0) return t[9:8];
        if (cbd && t[11:10] != 0) return t[11:10];
        if (cau && t[5:4] != 0) return t[5:4];
        if (cad && t[7:6] != 0) return t[7:6];
        return 2'd0;
    endfunction

    function automatic int n_active(logic ez, logic ep, logic cau, logic cad,
                                    logic cbu, logic cbd, logic [11:0] t);
        return int'(ez && t[1:0] != 0) + int'(ep && t[3:2] != 0) +
               int'(cbu && t[9:8] != 0) + int'(cbd && t[11:10] != 0) +
               int'(cau && t[5:4] != 0) + int'(cad && t[7:6] != 0);
    endfunction

    function automatic logic apply(logic cur, logic [1:0] c, logic fe, logic fv);
        if (fe) return fv;
        case (c)
            2'd1: return 1'b0;
            2'd2: return 1'b1;
            2'd3: return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_prd = 0; m_ca = 0; m_cb = 0; m_up = 1;
        m_a = 0; m_b = 0; m_ez = 0; m_ep = 0; m_eca = 0; m_ecb = 0; m_so = 0;
    endtask

    task automatic model_update();
        logic run, eu, ez, ep, cau, cad, cbu, cbd;
        logic [15:0] nc, np, na, nb;
        logic nu;
        run = tick_i && mode_i != 2'd3;
        eu  = (mode_i == 2'd0) ? 1'b1 : (mode_i == 2'd1) ? 1'b0 : m_up;
        ez  = run && m_cnt == 0;
        ep  = run && m_cnt == m_prd;
        cau = run && m_cnt == m_ca && eu;
        cad = run && m_cnt == m_ca && !eu;
        cbu = run && m_cnt == m_cb && eu;
        cbd = run && m_cnt == m_cb && !eu;
        nc = m_cnt; nu = m_up; np = m_prd; na = m_ca; nb = m_cb;
        if (ez) begin np = period_i; na = cmpa_i; nb = cmpb_i; end
        t_cnt = (mode_i == 2'd0) ? "R2" : (mode_i == 2'd1) ? "R3" :
                (mode_i == 2'd2) ? "R4" : "R12";
        if (run) begin
            if (mode_i == 2'd0) begin
                nu = 1; nc = (m_cnt >= m_prd) ? 16'd0 : m_cnt + 16'd1;
            end else if (mode_i == 2'd1) begin
                nu = 0; nc = (m_cnt == 0 || m_cnt > m_prd) ? m_prd : m_cnt - 16'd1;
            end else if (m_up) begin
                if (m_cnt >= m_prd) begin
                    nu = 0; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
                end else nc = m_cnt + 16'd1;
            end else if (m_cnt == 0) begin
                nu = 1; nc = (m_prd == 0) ? 16'd0 : 16'd1;
            end else nc = m_cnt - 16'd1;
        end
        if (sync_en_i && sync_in_i) begin
            nc = phase_i; nu = sync_dir_up_i; t_cnt = "R9";
        end
        t_a = frc_en_i[0] ? "R8" :
              (n_active(ez, ep, cau, cad, cbu, cbd, act_a_i) > 1) ? "R7" : "R6";
        t_b = frc_en_i[1] ? "R8" :
              (n_active(ez, ep, cau, cad, cbu, cbd, act_b_i) > 1) ? "R7" : "R6";
        m_a = apply(m_a, resolve(ez, ep, cau, cad, cbu, cbd, act_a_i), frc_en_i[0], frc_val_i[0]);
        m_b = apply(m_b, resolve(ez, ep, cau, cad, cbu, cbd, act_b_i), frc_en_i[1], frc_val_i[1]);
        m_ez = ez; m_ep = ep; m_eca = cau | cad; m_ecb = cbu | cbd;
        case (sync_sel_i)
            2'd0: m_so = sync_in_i;
            2'd1: m_so = ez;
            2'd2: m_so = cbu | cbd;
            default: m_so = 1'b0;
        endcase
        m_cnt = nc; m_up = nu; m_prd = np; m_ca = na; m_cb = nb;
    endtask

    task automatic chk(string tag, string nm, logic [15:0] got, logic [15:0] exp);
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, nm, got, exp);
        end
    endtask

    task automatic compare_all();
        n_vec++;
        chk(t_cnt, "cnt", cnt_o, m_cnt);
        chk(t_cnt, "dir", 16'(dir_up_o), 16'(m_up));
        chk(t_a, "pwm_a", 16'(pwm_a_o), 16'(m_a));
        chk(t_b, "pwm_b", 16'(pwm_b_o), 16'(m_b));
        chk("R10", "sync_out", 16'(sync_out_o), 16'(m_so));
        chk("R11", "evt_zero", 16'(evt_zero_o), 16'(m_ez));
        chk("R11", "evt_prd", 16'(evt_prd_o), 16'(m_ep));
        chk("R11", "evt_cmpa", 16'(evt_cmpa_o), 16'(m_eca));
        chk("R11", "evt_cmpb", 16'(evt_cmpb_o), 16'(m_ecb));
    endtask

    // inputs are held through the next rising edge; sample at the falling edge
    task automatic step();
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned mx;
        void'($urandom(32'd20240611));
        model_reset();
        t_cnt = "R1"; t_a = "R1"; t_b = "R1";
        repeat (3) @(negedge clk);
        compare_all();                      // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                      // R1 after release, no tick yet

        for (int blk = 0; blk < 40; blk++) begin
            bit always_tick;
            int unsigned p;
            mode_i      = 2'($urandom % 4);
            p           = $urandom % 24;
            period_i    = 16'(p);
            cmpa_i      = 16'($urandom % (p + 3));
            cmpb_i      = 16'($urandom % (p + 3));
            act_a_i     = 12'($urandom);
            act_b_i     = 12'($urandom);
            sync_sel_i  = 2'($urandom % 4);
            sync_en_i   = 1'($urandom % 2);
            always_tick = ($urandom % 2) == 0;
            for (int c = 0; c < 500; c++) begin
                tick_i        = always_tick ? 1'b1 : (($urandom % 4) != 0);
                sync_in_i     = (($urandom % 64) == 0);
                sync_dir_up_i = 1'($urandom);
                phase_i       = 16'($urandom % (p + 2));
                frc_en_i      = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
                frc_val_i     = 2'($urandom);
                if (($urandom % 100) == 0) begin
                    p        = $urandom % 24;
                    period_i = 16'(p);
                    cmpa_i   = 16'($urandom % (p + 3));
                end
                step();
            end
        end

        // Directed R5: period changed mid-cycle applies only after the next zero
        mode_i = 2'd0; tick_i = 1'b1; sync_in_i = 1'b0; frc_en_i = 2'b00;
        period_i = 16'd5;
        repeat (30) step();
        for (int k = 0; k < 20 && cnt_o != 16'd2; k++) step();
        period_i = 16'd9;
        mx = 0;
        step();
        for (int k = 0; k < 20 && cnt_o != 16'd0; k++) begin
            if (cnt_o > mx) mx = cnt_o;
            step();
        end
        n_vec++;
        if (mx != 5) begin
            n_bad++;
            $display("FAIL R5 old period peak: got %0d expected %0d", mx, 5);
        end
        mx = 0;
        step();
        for (int k = 0; k < 20 && cnt_o != 16'd0; k++) begin
            if (cnt_o > mx) mx = cnt_o;
            step();
        end
        n_vec++;
        if (mx != 9) begin
            n_bad++;
            $display("FAIL R5 new period peak: got %0d expected %0d", mx, 9);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule